// File: doc/BRIEF.md
# Privileged Instruction Trap Decider

This block is a purely combinational verdict unit for a processor's execute stage. It covers four privileged instruction classes: the wait-for-interrupt instruction, the supervisor address-translation fence, the hypervisor virtual-address fence and the hypervisor guest-physical fence. The stage presents the class together with the current privilege level, the virtualization flag, the supervisor-mode and hypervisor extension presence flags, and four trap-control bits:

- a wait-timeout bit from machine status,
- a translation-trap bit from machine status,
- a guest wait-timeout bit from hypervisor status,
- a guest translation-trap bit from hypervisor status.

The block answers in the same cycle with exactly one verdict: the instruction may proceed, it raises an illegal-instruction exception, or it raises a virtual-instruction exception.

A permitted wait instruction also raises a halt request, so the core can stop until an interrupt arrives. A permitted fence raises a flush request for the translation caches. The caches themselves lie outside this block. The illegal rules for each class are checked before its virtual rules. The guest-physical fence has one extra translation-trap check, which comes ahead of the rule it shares with the other hypervisor fence.

Top module: `priv_trap_decide`

## Requirements
- R1: When `ins_cls` is 0 (no instruction) or one of the unused codes 5, 6 or 7, all of `allow`, `trap_illegal`, `trap_virtual`, `halt_req` and `flush_req` are low.
- R2: For `ins_cls` 1 (wait), 2 (supervisor fence), 3 (hypervisor VA fence) or 4 (hypervisor guest-physical fence), exactly one of `allow`, `trap_illegal` and `trap_virtual` is high.
- R3: Wait (class 1) is illegal in either of two cases. The first is `tw_m` set while the privilege is S (`priv`=1), or U (`priv`=0) with `has_s` low. The second is privilege U with `has_s` high and `virt` low.
- R4: Wait that R3 does not make illegal raises `trap_virtual` when `virt` is high and either the privilege is U, or the privilege is S with `tw_h` set. In every other case it is allowed.
- R5: An allowed wait asserts `halt_req` and not `flush_req`. `halt_req` is never high without an allowed wait.
- R6: The supervisor fence (class 2) is illegal at privilege U, and also at privilege S with `tvm_m` set.
- R7: A supervisor fence that R6 does not make illegal raises `trap_virtual` when `has_h`, `virt` and `tvm_h` are all high. In every other case it is allowed.
- R8: Both hypervisor fences (classes 3 and 4) raise `trap_virtual` at privilege S with `virt` high.
- R9: A hypervisor fence not covered by R8 or R10 is allowed at privilege M (`priv`=3), or at S with `virt` low. In every other case it is illegal.
- R10: The guest-physical fence (class 4) is illegal at privilege S with `virt` low and `tvm_m` set. This check takes precedence over R9.
- R11: An allowed fence (classes 2 to 4) asserts `flush_req` and not `halt_req`. `flush_req` is never high without an allowed fence.
- R12: The reserved privilege code 2 makes every valid class illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ins_cls | input | 3 | Instruction class: 0 none, 1 wait, 2 supervisor fence, 3 hypervisor VA fence, 4 guest-physical fence |
| priv | input | 2 | Privilege level: 0 U, 1 S, 2 reserved, 3 M |
| virt | input | 1 | Virtualization mode active |
| has_s | input | 1 | Supervisor-mode extension present |
| has_h | input | 1 | Hypervisor extension present |
| tw_m | input | 1 | Machine wait-timeout trap bit |
| tvm_m | input | 1 | Machine translation trap bit |
| tw_h | input | 1 | Hypervisor guest wait-timeout trap bit |
| tvm_h | input | 1 | Hypervisor guest translation trap bit |
| allow | output | 1 | Instruction may execute |
| trap_illegal | output | 1 | Raise illegal-instruction exception |
| trap_virtual | output | 1 | Raise virtual-instruction exception |
| halt_req | output | 1 | Allowed wait: stall until interrupt |
| flush_req | output | 1 | Allowed fence: flush translation caches |

## Verification
Within a single instruction, the illegal rule and the virtual rule can both match in the same cycle. Examples are a wait in virtualized S mode with both timeout bits set, a supervisor fence with both translation bits set, and a guest-physical fence where the translation-trap check and the shared hypervisor rule both apply. The bench provokes every such overlap by sweeping all 4096 combinations of class, privilege and the seven flag bits. It judges each cycle against a priority model of its own, in which the illegal rule always wins and the extra guest-physical check is applied first.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

    localparam int CLS_W  = 3;
    localparam int PRIV_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE     = 3'd0,
        CLS_WFI      = 3'd1,
        CLS_SFENCE   = 3'd2,
        CLS_HFENCE_V = 3'd3,
        CLS_HFENCE_G = 3'd4
    } ins_cls_e;

    typedef enum logic [PRIV_W-1:0] {
        LVL_U    = 2'd0,
        LVL_S    = 2'd1,
        LVL_RSVD = 2'd2,
        LVL_M    = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        VD_NONE    = 2'd0,
        VD_ALLOW   = 2'd1,
        VD_ILLEGAL = 2'd2,
        VD_VIRTUAL = 2'd3
    } verdict_e;

    typedef struct packed {
        logic allow;
        logic illegal;
        logic virtual_f;
        logic halt;
        logic flush;
    } decision_t;

    function automatic logic cls_valid(input logic [CLS_W-1:0] c);
        return (c >= CLS_WFI) && (c <= CLS_HFENCE_G);
    endfunction

    // Illegal first, then virtual, otherwise allowed.
    function automatic verdict_e pick(input logic ill, input logic vrt);
        if (ill)      return VD_ILLEGAL;
        else if (vrt) return VD_VIRTUAL;
        else          return VD_ALLOW;
    endfunction

endpackage

// File: rtl/ptd_wfi_rule.sv
module ptd_wfi_rule
    import priv_trap_pkg::*;
(
    input  logic [PRIV_W-1:0] priv,
    input  logic              virt,
    input  logic              has_s,
    input  logic              tw_m,
    input  logic              tw_h,
    output verdict_e          verdict
);
    logic at_u, at_s, ill, vrt;

    always_comb begin
        at_u = (priv == LVL_U);
        at_s = (priv == LVL_S);
        ill  = (tw_m && (at_s || (at_u && !has_s))) || (has_s && at_u && !virt);
        vrt  = virt && (at_u || (at_s && tw_h));
        verdict = pick(ill, vrt);
    end
endmodule

// File: rtl/ptd_sfence_rule.sv
module ptd_sfence_rule
    import priv_trap_pkg::*;
(
    input  logic [PRIV_W-1:0] priv,
    input  logic              virt,
    input  logic              has_h,
    input  logic              tvm_m,
    input  logic              tvm_h,
    output verdict_e          verdict
);
    logic ill, vrt;

    always_comb begin
        ill = (priv == LVL_U) || ((priv == LVL_S) && tvm_m);
        vrt = has_h && virt && tvm_h;
        verdict = pick(ill, vrt);
    end
endmodule

// File: rtl/ptd_hfence_rule.sv
module ptd_hfence_rule
    import priv_trap_pkg::*;
#(
    parameter bit GUEST_PHYS = 1'b0
) (
    input  logic [PRIV_W-1:0] priv,
    input  logic              virt,
    input  logic              tvm_m,
    output verdict_e          verdict
);
    logic at_s, tvm_gate, pre_ill, vrt, permitted;

    always_comb begin
        at_s      = (priv == LVL_S);
        tvm_gate  = GUEST_PHYS ? tvm_m : 1'b0;
        pre_ill   = at_s && !virt && tvm_gate;
        vrt       = at_s && virt;
        permitted = (priv == LVL_M) || (at_s && !virt);
        if (pre_ill)        verdict = VD_ILLEGAL;
        else if (vrt)       verdict = VD_VIRTUAL;
        else if (permitted) verdict = VD_ALLOW;
        else                verdict = VD_ILLEGAL;
    end
endmodule

// File: rtl/priv_trap_decide.sv
module priv_trap_decide
    import priv_trap_pkg::*;
(
    input  logic [2:0] ins_cls,
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic       has_s,
    input  logic       has_h,
    input  logic       tw_m,
    input  logic       tvm_m,
    input  logic       tw_h,
    input  logic       tvm_h,
    output logic       allow,
    output logic       trap_illegal,
    output logic       trap_virtual,
    output logic       halt_req,
    output logic       flush_req
);
    localparam int N_HF = 2;

    verdict_e  vd_wfi, vd_sf, vd_sel;
    verdict_e  vd_hf [N_HF];
    decision_t dec;

    ptd_wfi_rule u_wfi (
        .priv(priv), .virt(virt), .has_s(has_s),
        .tw_m(tw_m), .tw_h(tw_h), .verdict(vd_wfi)
    );

    ptd_sfence_rule u_sf (
        .priv(priv), .virt(virt), .has_h(has_h),
        .tvm_m(tvm_m), .tvm_h(tvm_h), .verdict(vd_sf)
    );

    for (genvar g = 0; g < N_HF; g++) begin : g_hf
        ptd_hfence_rule #(.GUEST_PHYS(g == 1)) u_hf (
            .priv(priv), .virt(virt), .tvm_m(tvm_m), .verdict(vd_hf[g])
        );
    end

    always_comb begin
        case (ins_cls)
            CLS_WFI:      vd_sel = vd_wfi;
            CLS_SFENCE:   vd_sel = vd_sf;
            CLS_HFENCE_V: vd_sel = vd_hf[0];
            CLS_HFENCE_G: vd_sel = vd_hf[1];
            default:      vd_sel = VD_NONE;
        endcase
        if (cls_valid(ins_cls) && priv == LVL_RSVD)
            vd_sel = VD_ILLEGAL;

        dec           = '0;
        dec.allow     = (vd_sel == VD_ALLOW);
        dec.illegal   = (vd_sel == VD_ILLEGAL);
        dec.virtual_f = (vd_sel == VD_VIRTUAL);
        dec.halt      = dec.allow && (ins_cls == CLS_WFI);
        dec.flush     = dec.allow && (ins_cls != CLS_WFI);
    end

    assign allow        = dec.allow;
    assign trap_illegal = dec.illegal;
    assign trap_virtual = dec.virtual_f;
    assign halt_req     = dec.halt;
    assign flush_req    = dec.flush;
endmodule

// File: rtl/priv_trap_decide_chk.sv
module priv_trap_decide_chk (
    input logic [2:0] ins_cls,
    input logic [1:0] priv,
    input logic       virt,
    input logic       has_s,
    input logic       has_h,
    input logic       tw_m,
    input logic       tvm_m,
    input logic       tw_h,
    input logic       tvm_h,
    input logic       allow,
    input logic       trap_illegal,
    input logic       trap_virtual,
    input logic       halt_req,
    input logic       flush_req
);
    logic valid;
    assign valid = (ins_cls >= 3'd1) && (ins_cls <= 3'd4);

    always_comb begin
        // R1
        idle_quiet_chk: assert (valid || {allow, trap_illegal, trap_virtual, halt_req, flush_req} == 5'b0);
        // R2
        one_outcome_chk: assert (!valid || $countones({allow, trap_illegal, trap_virtual}) == 1);
        // R5
        halt_only_wfi_chk: assert (!halt_req || (allow && ins_cls == 3'd1));
        // R11
        flush_only_fence_chk: assert (!flush_req || (allow && ins_cls != 3'd1 && !halt_req));
        // R12
        rsvd_priv_chk: assert (!(valid && priv == 2'd2) || trap_illegal);
        // R6
        sfence_user_chk: assert (!(ins_cls == 3'd2 && priv == 2'd0) || trap_illegal);
        // R8
        hfence_guest_chk: assert (!((ins_cls == 3'd3 || ins_cls == 3'd4) && priv == 2'd1 && virt) || trap_virtual);
        // R10
        gfence_tvm_chk: assert (!(ins_cls == 3'd4 && priv == 2'd1 && !virt && tvm_m) || trap_illegal);
    end

    logic unused_ok;
    assign unused_ok = ^{has_s, has_h, tw_m, tw_h, tvm_h};
endmodule

bind priv_trap_decide priv_trap_decide_chk u_chk (.*);

// File: tb/priv_trap_decide_test.sv
`timescale 1ns/1ps
module priv_trap_decide_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [2:0] ins_cls;
    logic [1:0] priv;
    logic virt, has_s, has_h, tw_m, tvm_m, tw_h, tvm_h;
    logic allow, trap_illegal, trap_virtual, halt_req, flush_req;

    priv_trap_decide uut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Expected {allow, illegal, virtual}, plus a tag naming the rule that decided.
    task automatic model(input logic [2:0] c, input logic [1:0] p,
                         input logic v, input logic s, input logic h,
                         input logic tw, input logic tvm, input logic vtw, input logic vtvm,
                         output logic [2:0] exp, output string tag);
        bit u = (p == 2'd0), sm = (p == 2'd1), m = (p == 2'd3);
        exp = 3'b000; tag = "R1";
        if (c == 0 || c > 4) begin exp = 3'b000; tag = "R1"; end
        else if (p == 2'd2) begin exp = 3'b010; tag = "R12"; end
        else if (c == 1) begin
            if ((u && s && !v) || (tw && (sm || (u && !s)))) begin exp = 3'b010; tag = "R3"; end
            else if (v && (u || (sm && vtw)))                begin exp = 3'b001; tag = "R4"; end
            else                                             begin exp = 3'b100; tag = "R4"; end
        end else if (c == 2) begin
            if (u || (sm && tvm))    begin exp = 3'b010; tag = "R6"; end
            else if (h && v && vtvm) begin exp = 3'b001; tag = "R7"; end
            else                     begin exp = 3'b100; tag = "R7"; end
        end else begin
            if (c == 4 && sm && !v && tvm) begin exp = 3'b010; tag = "R10"; end
            else if (sm && v)              begin exp = 3'b001; tag = "R8"; end
            else if (m || (sm && !v))      begin exp = 3'b100; tag = "R9"; end
            else                           begin exp = 3'b010; tag = "R9"; end
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [2:0] exp3;
        logic [4:0] got;
        string tag;
        {ins_cls, priv, virt, has_s, has_h, tw_m, tvm_m, tw_h, tvm_h} = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state, no instruction presented
        got = {allow, trap_illegal, trap_virtual, halt_req, flush_req};
        check(got == 5'b0, "R1", "reset idle", got, 5'b0);
        rst = 1'b0;

        for (int vec = 0; vec < 4096; vec++) begin
            @(posedge clk); #1;
            {tvm_h, tw_h, tvm_m, tw_m, has_h, has_s, virt, priv, ins_cls} = vec[11:0];
            @(negedge clk);
            model(ins_cls, priv, virt, has_s, has_h, tw_m, tvm_m, tw_h, tvm_h, exp3, tag);
            got = {allow, trap_illegal, trap_virtual, halt_req, flush_req};
            check({allow, trap_illegal, trap_virtual} == exp3, tag,
                  $sformatf("verdict cls=%0d priv=%0d flags=%b", ins_cls, priv, vec[11:5]),
                  {2'b0, allow, trap_illegal, trap_virtual}, {2'b0, exp3});
            // R5 halt for allowed wait, R11 flush for allowed fence
            check({halt_req, flush_req} == {exp3[2] && ins_cls == 3'd1, exp3[2] && ins_cls != 3'd1},
                  (ins_cls == 3'd1) ? "R5" : "R11",
                  $sformatf("halt/flush cls=%0d priv=%0d", ins_cls, priv),
                  {3'b0, halt_req, flush_req},
                  {3'b0, exp3[2] && ins_cls == 3'd1, exp3[2] && ins_cls != 3'd1});
            // R2 exactly one verdict for valid classes
            if (ins_cls >= 3'd1 && ins_cls <= 3'd4)
                check($countones({allow, trap_illegal, trap_virtual}) == 1, "R2", "onehot",
                      {2'b0, allow, trap_illegal, trap_virtual}, 5'b0);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule